// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel. It advances only in system clock cycles where a one-cycle count-enable pulse is present, so the whole design runs from one clock. A load strobe supplies the initial count, an operating mode (0 to 5) and a flag that selects binary or decimal (BCD) counting. The channel presents its live count value and an output level. A gate input can restart the count in the modes that are retriggerable.

The six modes cover the usual timer functions. These are interrupt on terminal count, retriggerable one-shot, rate generator, square wave, and software- or gate-started single-count strobes. A loaded count of zero stands for the largest count. A snapshot register captures the output level on request, for use by a separate status read-back block. Host byte sequencing, count latching and interrupt delivery belong to the surrounding logic.

Top module: `pit_channel`

## Requirements
- R1: After reset the count reads 0, the output is high and the snapshot is 0. Count enables and gate edges change nothing until the first load.
- R2: In the cycle after a load strobe the count shows the loaded value, and the elapsed count restarts at 0. The count moves only in cycles with `cnt_en` high. A mode code of 6 acts as mode 2, and 7 acts as mode 3.
- R3: A loaded count of 0 behaves as 65536 in binary and as 10000 in BCD.
- R4: In BCD each 4-bit digit steps down as a decimal digit, borrowing from the next digit. The count wraps from 0 to 0x9999 in BCD and to 0xFFFF in binary.
- R5: Mode 0 sets the output low at load. The output goes high once the elapsed count reaches N and stays high. The count keeps wrapping.
- R6: Mode 1 drives the output like mode 0: low until elapsed count N, then high.
- R7: Mode 2 reloads N after every N counts. The output is high for exactly the one count at each nonzero multiple of N, and low otherwise.
- R8: Mode 3 steps the count by two. The output is high for the first ceil(N/2) counts of each N-count period and low for the rest. With N = 1 the output stays high.
- R9: Modes 4 and 5 hold the output low except during the single count at which the elapsed count equals N.
- R10: A gate rising edge in modes 1, 2, 3 and 5 restarts from N with the output at its start level (high in mode 3, low otherwise). The restart takes priority over a count enable in the same cycle, and a load takes priority over both. In modes 0 and 4 gate edges have no effect.
- R11: A snapshot strobe copies the output level seen in that cycle into `out_snap`, which holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | One-cycle count step enable |
| gate | input | 1 | Gate level; rising edge retriggers in modes 1, 2, 3, 5 |
| load | input | 1 | Load strobe for count, mode and number format |
| load_count | input | 16 | Initial count N (0 means the maximum) |
| load_mode | input | 3 | Operating mode code 0 to 7 |
| load_bcd | input | 1 | 1 selects decimal counting |
| snap_stb | input | 1 | Capture the output level into the snapshot |
| count_o | output | 16 | Current count value |
| out_o | output | 1 | Output level |
| out_snap | output | 1 | Captured output level |

## Verification
Two pairs of events can fall in the same cycle. A load or a gate rising edge can arrive together with a count enable. The bench provokes both by holding `cnt_en` high every cycle while it pulses `load` during a running count, and while it raises `gate` during one-shot, strobe and square-wave runs. A bench-side arithmetic model of elapsed counts judges the result: after a collision the elapsed count must read 0, not 1, in both the count value and the output level of the next cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [2:0] {
      PM_TERM     = 3'd0,
      PM_ONESHOT  = 3'd1,
      PM_RATE     = 3'd2,
      PM_SQUARE   = 3'd3,
      PM_SWSTROBE = 3'd4,
      PM_HWSTROBE = 3'd5
   } pit_mode_e;

   // Codes 6 and 7 alias the two periodic modes
   function automatic pit_mode_e fold_mode(input logic [2:0] code);
      if (code[2] && code[1])
         return pit_mode_e'({1'b0, code[1:0]});
      return pit_mode_e'(code);
   endfunction

   function automatic logic gate_retriggers(input pit_mode_e m);
      return (m == PM_ONESHOT) || (m == PM_RATE) ||
             (m == PM_SQUARE)  || (m == PM_HWSTROBE);
   endfunction

endpackage

// File: rtl/pit_digit_dec.sv
// Subtract one from a value built of 4-bit digits; each digit wraps to
// 9 (decimal) or F (binary) and borrows from the digit above.
module pit_digit_dec #(
   parameter int CW = 16
) (
   input  logic [CW-1:0] val,
   input  logic          bcd,
   output logic [CW-1:0] res
);
   localparam int ND = CW / 4;

   logic [ND:0] brw;
   assign brw[0] = 1'b1;

   for (genvar i = 0; i < ND; i++) begin : g_dig
      logic [3:0] dig;
      assign dig = val[4*i +: 4];
      assign res[4*i +: 4] = !brw[i]       ? dig :
                             (dig == 4'd0) ? (bcd ? 4'd9 : 4'hF) :
                                             dig - 4'd1;
      assign brw[i+1] = brw[i] & (dig == 4'd0);
   end

endmodule

// File: rtl/pit_edge.sv
module pit_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic rise
);
   logic sig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sig_q <= 1'b0;
      else        sig_q <= sig;
   end

   assign rise = sig & ~sig_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_en,
   input  logic          gate,
   input  logic          load,
   input  logic [CW-1:0] load_count,
   input  logic [2:0]    load_mode,
   input  logic          load_bcd,
   input  logic          snap_stb,
   output logic [CW-1:0] count_o,
   output logic          out_o,
   output logic          out_snap
);
   localparam logic [CW-1:0] ONE  = CW'(1);
   localparam logic [CW-1:0] TWO  = CW'(2);
   localparam logic [CW-1:0] ZERO = '0;

   if ((CW % 4) != 0 || CW < 8) begin : g_bad_width
      $error("pit_channel: CW must be a multiple of 4 and at least 8");
   end

   logic [CW-1:0] cnt, init_q, m1, m2;
   pit_mode_e     mode_q, mode_in;
   logic          bcd_q, run_q, first_q, low_half_q, out_q, snap_q;
   logic          gate_rise, init_is_one;

   pit_digit_dec #(.CW(CW)) u_dec1 (.val(cnt), .bcd(bcd_q), .res(m1));
   pit_digit_dec #(.CW(CW)) u_dec2 (.val(m1),  .bcd(bcd_q), .res(m2));
   pit_edge u_gate (.clk(clk), .rst_n(rst_n), .sig(gate), .rise(gate_rise));

   assign mode_in     = fold_mode(load_mode);
   assign init_is_one = (init_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt        <= ZERO;
         init_q     <= ZERO;
         mode_q     <= PM_TERM;
         bcd_q      <= 1'b0;
         run_q      <= 1'b0;
         first_q    <= 1'b0;
         low_half_q <= 1'b0;
         out_q      <= 1'b1;
         snap_q     <= 1'b0;
      end else begin
         if (snap_stb) snap_q <= out_q;

         if (load) begin
            init_q     <= load_count;
            cnt        <= load_count;
            mode_q     <= mode_in;
            bcd_q      <= load_bcd;
            run_q      <= 1'b1;
            first_q    <= 1'b1;
            low_half_q <= 1'b0;
            out_q      <= (mode_in == PM_SQUARE);
         end else if (run_q && gate_rise && gate_retriggers(mode_q)) begin
            cnt        <= init_q;
            first_q    <= 1'b1;
            low_half_q <= 1'b0;
            out_q      <= (mode_q == PM_SQUARE);
         end else if (run_q && cnt_en) begin
            case (mode_q)
               PM_RATE: begin
                  if (cnt == ONE) begin
                     cnt   <= init_q;
                     out_q <= 1'b1;
                  end else begin
                     cnt   <= m1;
                     out_q <= 1'b0;
                  end
               end
               PM_SQUARE: begin
                  if (cnt == ONE || cnt == TWO) begin
                     if (!low_half_q && !init_is_one) begin
                        low_half_q <= 1'b1;
                        out_q      <= 1'b0;
                        cnt        <= {init_q[CW-1:1], 1'b0};
                     end else begin
                        low_half_q <= 1'b0;
                        out_q      <= 1'b1;
                        cnt        <= init_q;
                     end
                  end else begin
                     cnt <= m2;
                  end
               end
               PM_SWSTROBE, PM_HWSTROBE: begin
                  cnt   <= m1;
                  out_q <= first_q && (m1 == ZERO);
                  if (first_q && m1 == ZERO) first_q <= 1'b0;
               end
               default: begin
                  cnt <= m1;
                  if (first_q && m1 == ZERO) begin
                     out_q   <= 1'b1;
                     first_q <= 1'b0;
                  end
               end
            endcase
         end
      end
   end

   assign count_o  = cnt;
   assign out_o    = out_q;
   assign out_snap = snap_q;

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cnt_en,
   input logic          load,
   input logic          snap_stb,
   input logic [CW-1:0] load_count,
   input logic [CW-1:0] count_o,
   input logic          out_o,
   input logic          out_snap,
   input logic          run_q,
   input logic [2:0]    mode_q,
   input logic          gate_rise
);

   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !load) |=> (out_o && $stable(count_o)));

   a_r2_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count_o == $past(load_count)));

   a_r2_no_step_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load && !gate_rise) |=> $stable(count_o));

   a_r5_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mode_q == 3'd0 && out_o && !load) |=> out_o);

   a_r9_strobe_one_count: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && (mode_q == 3'd4 || mode_q == 3'd5) && out_o && cnt_en && !load && !gate_rise)
      |=> !out_o);

   a_r11_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      snap_stb |=> (out_snap == $past(out_o)));

endmodule

bind pit_channel pit_channel_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load(load), .snap_stb(snap_stb),
   .load_count(load_count), .count_o(count_o), .out_o(out_o), .out_snap(out_snap),
   .run_q(run_q), .mode_q(mode_q), .gate_rise(gate_rise)
);

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0, gate = 1'b0, load = 1'b0, load_bcd = 1'b0, snap_stb = 1'b0;
   logic [15:0] load_count = '0;
   logic [2:0]  load_mode = '0;
   logic [15:0] count_o;
   logic        out_o, out_snap;

   always #2.5 clk = ~clk;

   pit_channel #(.CW(16)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .load(load),
      .load_count(load_count), .load_mode(load_mode), .load_bcd(load_bcd),
      .snap_stb(snap_stb), .count_o(count_o), .out_o(out_o), .out_snap(out_snap)
   );

   int  total = 0, bad = 0;
   bit  done = 0;
   // reference model
   int  m_mode = 0, m_neff = 1, m_mod = 65536, d = 0;
   bit  m_bcd = 0, started = 0, prev_gate = 0, exp_snap = 0;

   function automatic int enc(int v);
      if (!m_bcd) return v;
      return (v % 10) | (((v / 10) % 10) << 4) | (((v / 100) % 10) << 8) | (((v / 1000) % 10) << 12);
   endfunction

   function automatic int exp_cnt();
      int v, p, h;
      if (!started) return 0;
      case (m_mode)
         2: v = (m_neff - (d % m_neff)) % m_mod;
         3: begin
            p = d % m_neff; h = (m_neff + 1) / 2;
            if (p < h) v = (m_neff - 2*p) % m_mod;
            else       v = ((m_neff & ~1) - 2*(p - h)) % m_mod;
         end
         default: v = (((m_neff - d) % m_mod) + m_mod) % m_mod;
      endcase
      return enc(v);
   endfunction

   function automatic bit exp_out();
      if (!started) return 1'b1;
      case (m_mode)
         0, 1: return d >= m_neff;
         2:    return (d != 0) && (d % m_neff == 0);
         3:    return (d % m_neff) < ((m_neff + 1) / 2);
         default: return d == m_neff;
      endcase
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      chk(int'(count_o) == exp_cnt(), {tag, " count"}, int'(count_o), exp_cnt());
      chk(out_o == exp_out(), {tag, " out"}, int'(out_o), int'(exp_out()));
   endtask

   task automatic step(string tag, bit en, bit g, bit snp);
      bit rise, old_out;
      @(negedge clk);
      cnt_en = en; gate = g; snap_stb = snp; load = 1'b0;
      old_out = exp_out();
      @(posedge clk); #1;
      rise = g && !prev_gate;
      prev_gate = g;
      if (started) begin
         if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) d = 0;
         else if (en) d++;
      end
      compare(tag);
      if (snp) begin
         exp_snap = old_out;
         chk(out_snap == exp_snap, "R11 snapshot", int'(out_snap), int'(exp_snap));
      end
   endtask

   // load with a count enable in the same cycle: load must win (R2, R10)
   task automatic do_load(string tag, int nraw, int mraw, bit bcd);
      int nv;
      @(negedge clk);
      load = 1'b1; load_count = nraw[15:0]; load_mode = mraw[2:0]; load_bcd = bcd;
      cnt_en = 1'b1; gate = 1'b0; snap_stb = 1'b0;
      @(posedge clk); #1;
      prev_gate = 1'b0;
      m_mode = (mraw >= 6) ? mraw - 4 : mraw;
      m_bcd  = bcd;
      m_mod  = bcd ? 10000 : 65536;
      if (bcd) nv = (nraw & 15) + 10*((nraw >> 4) & 15) + 100*((nraw >> 8) & 15) + 1000*((nraw >> 12) & 15);
      else     nv = nraw;
      m_neff = (nv == 0) ? m_mod : nv;
      d = 0; started = 1;
      compare({tag, " R2 load"});
   endtask

   task automatic run(string tag, int cycles, int en_period, int rise_at);
      for (int i = 0; i < cycles; i++)
         step(tag, (i % en_period) == 0, (rise_at >= 0) && (i >= rise_at), (i % 3) == 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(int'(count_o) == 0, "R1 reset count", int'(count_o), 0);
      chk(out_o == 1'b1, "R1 reset out", int'(out_o), 1);
      chk(out_snap == 1'b0, "R1 reset snap", int'(out_snap), 0);
      @(negedge clk); rst_n = 1'b1;
      run("R1 idle", 6, 1, 2);

      do_load("R5", 5, 0, 0);            run("R5 R4 term wrap", 12, 1, -1);
      do_load("R2", 7, 0, 0);            run("R2 sparse enable", 20, 2, 4);
      do_load("R10", 9, 0, 0);           run("R10 load collision", 3, 1, -1);
      do_load("R10", 4, 0, 0);           run("R10 reload", 8, 1, -1);
      do_load("R3", 0, 0, 0);            run("R3 binary 65536", 65540, 1, -1);
      do_load("R3", 0, 0, 1);            run("R3 R4 bcd 10000", 10003, 1, -1);
      do_load("R4", 'h0103, 4, 1);       run("R4 bcd borrow", 110, 1, -1);
      do_load("R6", 6, 1, 0);            run("R6 R10 oneshot retrigger", 14, 1, 3);
      do_load("R6", 3, 1, 0);            run("R6 oneshot", 8, 1, 6);
      do_load("R7", 4, 2, 0);            run("R7 rate", 14, 1, -1);
      do_load("R7", 1, 2, 0);            run("R7 rate n1", 6, 1, -1);
      do_load("R2", 3, 6, 0);            run("R2 R7 code6", 10, 1, 5);
      do_load("R8", 5, 3, 0);            run("R8 square odd", 16, 1, -1);
      do_load("R8", 6, 3, 0);            run("R8 square even", 16, 1, 9);
      do_load("R8", 1, 3, 0);            run("R8 square n1", 5, 1, -1);
      do_load("R8", 2, 3, 0);            run("R8 square n2", 6, 1, -1);
      do_load("R8", 'h15, 3, 1);         run("R8 R4 square bcd", 40, 1, -1);
      do_load("R2", 4, 7, 0);            run("R2 R8 code7", 10, 2, -1);
      do_load("R3", 0, 3, 1);            run("R3 R8 square bcd max", 10002, 1, -1);
      do_load("R9", 3, 4, 0);            run("R9 R10 strobe gate ignored", 10, 1, 1);
      do_load("R9", 3, 5, 0);            run("R9 R10 hw strobe retrigger", 12, 1, 2);
      do_load("R5", 2, 0, 0);            run("R10 term gate ignored", 6, 1, 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule